// File: doc/BRIEF.md
# SCSI Controller Register and Interrupt Unit

This block is the byte-wide register front end of a simple SCSI bus controller. A host reads and writes an address space of 64 byte registers through a synchronous port. A written image holds the transfer counter bytes and a configuration byte. A separate readable image presents the active transfer counter, the status, the interrupt reason, the sequence step and the FIFO fill level. A 32-byte data FIFO sits behind one register address. Writing that address pushes a byte. Reading it pops the oldest byte.

Command bytes written to the command register select DMA or programmed-I/O mode. A DMA command copies the written counter into the readable counter. One command code resets the bus. When the external DMA engine finishes, it pulses `dma_done`. The unit then marks terminal count, records a bus-service reason, clears the counter and raises `irq`. Software acknowledges the interrupt by reading the interrupt-reason register. That read clears the pending and error status bits as a side effect and drops `irq`.

Reads are combinational. `rdata` shows the register value from before any side effect of that cycle. Side effects take place at the clock edge that samples `rd_en`. Every port is a plain control or status pin. The unit has no streaming handshake, so back-pressure does not arise: a push into a full FIFO is dropped, and a pop from an empty FIFO returns zero.

Top module: `scsi_regif`

## Requirements
- R1: The readable counter is 16 bits: address 0 holds the low byte and address 1 the high byte. `xfer_bytes` reports that counter, or 65536 when the counter is zero.
- R2: A write to address 3 whose bit 7 is set sets `dma_mode` and copies the written counter bytes into the readable counter. A command byte with bit 7 clear clears `dma_mode` and leaves the readable counter unchanged.
- R3: A write to address 0 or address 1 clears status bit 4 (terminal count) on the next cycle. The readable counter is not changed by that write.
- R4: Status is read at address 4. Bit 7 means interrupt pending, bit 6 gross error, bit 5 parity error, bit 4 terminal count, and bits 2:0 hold the bus phase. Reading address 4 has no side effect.
- R5: Reading address 5 returns the interrupt reason. The read clears status bits 7, 6 and 5 and deasserts `irq`. It keeps status bit 4 and bits 2:0.
- R6: A `dma_done` pulse ORs 0x90 into status and sets the reason to 0x10 (bus service). It zeroes addresses 0, 1, 6 and 7 as read, and asserts `irq` on the next cycle.
- R7: A command whose bits 6:0 equal 0x03 (bus reset) sets the reason to 0x80. It asserts `irq` only when bit 6 of the configuration byte last written to address 8 is clear.
- R8: After reset every readable register is zero except address 0x0E, which reads 4. `irq` and `dma_mode` are low and the FIFO is empty.
- R9: The FIFO holds up to 32 bytes and returns them in write order at address 2. A push into a full FIFO is dropped. A pop from an empty FIFO returns 0 and changes nothing. After each accepted push or pop, address 7 holds the new fill level.
- R10: When `dma_done` falls in the same cycle as an address-5 read, a counter write or a command write, the completion update wins. `irq`, status bits 7 and 4, the reason and the zeroed counter all take their completion values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe; side effects at the sampling edge |
| rdata | output | 8 | Read data of the addressed register, before side effects |
| dma_done | input | 1 | One-cycle pulse marking the end of a DMA transfer |
| irq | output | 1 | Level interrupt request |
| dma_mode | output | 1 | High after a DMA command, low after a programmed-I/O command |
| xfer_bytes | output | 17 | Byte length of the readable counter, zero meaning 65536 |

## Verification
The completion pulse from the DMA side is independent of the host port. So it can fall in the same cycle as an interrupt acknowledge, a counter write or a DMA command. The bench drives each of these host accesses in the very cycle that `dma_done` pulses. It then reads status, reason and counter back through the ports. It expects `irq` to stay high, status bits 7 and 4 to be set, the reason to read 0x10 and the counter to read zero. A behavioural model that applies the same priority is compared against the outputs on every clock.

// File: rtl/scsi_regif_pkg.sv
package scsi_regif_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 8;
  localparam int CNT_W  = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] A_CNT_LO = 6'h00;
  localparam logic [ADDR_W-1:0] A_CNT_HI = 6'h01;
  localparam logic [ADDR_W-1:0] A_FIFO   = 6'h02;
  localparam logic [ADDR_W-1:0] A_CMD    = 6'h03;
  localparam logic [ADDR_W-1:0] A_STAT   = 6'h04;
  localparam logic [ADDR_W-1:0] A_RSN    = 6'h05;
  localparam logic [ADDR_W-1:0] A_SEQ    = 6'h06;
  localparam logic [ADDR_W-1:0] A_LEVEL  = 6'h07;
  localparam logic [ADDR_W-1:0] A_CFG    = 6'h08;
  localparam logic [ADDR_W-1:0] A_IDENT  = 6'h0E;

  localparam logic [DATA_W-1:0] IDENT_CODE  = 8'h04;
  localparam logic [DATA_W-1:0] RSN_SERVICE = 8'h10;
  localparam logic [DATA_W-1:0] RSN_BUSRST  = 8'h80;
  localparam logic [6:0]        OP_BUSRST   = 7'h03;

  localparam int ST_PEND  = 7;
  localparam int ST_GROSS = 6;
  localparam int ST_PAR   = 5;
  localparam int ST_TC    = 4;
  localparam int CFG_MUTE = 6;
endpackage

// File: rtl/scsi_regif_fifo.sv
module scsi_regif_fifo #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             moved,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic [$clog2(DEPTH+1)-1:0] level_nx
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic             push_ok, pop_ok;

  assign push_ok = push && (level != LW'(DEPTH));
  assign pop_ok  = pop && (level != '0);
  assign moved   = push_ok || pop_ok;
  assign level_nx = level + LW'(push_ok) - LW'(pop_ok);
  assign head    = (level != '0) ? mem[rptr] : '0;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      level <= level_nx;
      if (level_nx == '0) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (push_ok) wptr <= bump(wptr);
        if (pop_ok)  rptr <= bump(rptr);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end
endmodule

// File: rtl/scsi_regif_irq.sv
module scsi_regif_irq
  import scsi_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ack_rd,
  input  logic              cnt_wr,
  input  logic              busrst_cmd,
  input  logic              busrst_mute,
  input  logic              dma_done,
  output logic [DATA_W-1:0] status,
  output logic [DATA_W-1:0] reason,
  output logic              irq
);
  logic [DATA_W-1:0] status_nx, reason_nx;
  logic              irq_nx;

  always_comb begin
    status_nx = status;
    reason_nx = reason;
    irq_nx    = irq;
    if (ack_rd) begin
      status_nx[ST_PEND]  = 1'b0;
      status_nx[ST_GROSS] = 1'b0;
      status_nx[ST_PAR]   = 1'b0;
      irq_nx              = 1'b0;
    end
    if (cnt_wr) status_nx[ST_TC] = 1'b0;
    if (busrst_cmd) begin
      reason_nx = RSN_BUSRST;
      if (!busrst_mute) irq_nx = 1'b1;
    end
    if (dma_done) begin
      status_nx[ST_PEND] = 1'b1;
      status_nx[ST_TC]   = 1'b1;
      reason_nx          = RSN_SERVICE;
      irq_nx             = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      reason <= '0;
      irq    <= 1'b0;
    end else begin
      status <= status_nx;
      reason <= reason_nx;
      irq    <= irq_nx;
    end
  end
endmodule

// File: rtl/scsi_regif.sv
module scsi_regif
  import scsi_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata,
  input  logic              dma_done,
  output logic              irq,
  output logic              dma_mode,
  output logic [CNT_W:0]    xfer_bytes
);
  localparam int LW = $clog2(FIFO_DEPTH + 1);

  logic [DATA_W-1:0] wcnt [2];
  logic [DATA_W-1:0] rcnt [2];
  logic [DATA_W-1:0] cfg_q, seq_q, level_q;
  logic [DATA_W-1:0] stat_q, rsn_q, fifo_head;
  logic [LW-1:0]     fifo_lvl, fifo_lvl_nx;
  logic              fifo_moved, dma_mode_q;
  logic              cnt_wr, cmd_wr, busrst_cmd, ack_rd, push, pop;

  assign cnt_wr     = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);
  assign cmd_wr     = wr_en && (addr == A_CMD);
  assign busrst_cmd = cmd_wr && (wdata[6:0] == OP_BUSRST);
  assign ack_rd     = rd_en && (addr == A_RSN);
  assign push       = wr_en && (addr == A_FIFO);
  assign pop        = rd_en && (addr == A_FIFO);

  scsi_regif_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(wdata), .pop(pop),
    .head(fifo_head), .moved(fifo_moved), .level(fifo_lvl), .level_nx(fifo_lvl_nx)
  );

  scsi_regif_irq u_irq (
    .clk(clk), .rst_n(rst_n), .ack_rd(ack_rd), .cnt_wr(cnt_wr),
    .busrst_cmd(busrst_cmd), .busrst_mute(cfg_q[CFG_MUTE]), .dma_done(dma_done),
    .status(stat_q), .reason(rsn_q), .irq(irq)
  );

  for (genvar b = 0; b < 2; b++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wcnt[b] <= '0;
        rcnt[b] <= '0;
      end else begin
        if (wr_en && addr == ADDR_W'(b)) wcnt[b] <= wdata;
        if (cmd_wr && wdata[7]) rcnt[b] <= wcnt[b];
        if (dma_done) rcnt[b] <= '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q      <= '0;
      seq_q      <= '0;
      level_q    <= '0;
      dma_mode_q <= 1'b0;
    end else begin
      if (wr_en && addr == A_CFG) cfg_q <= wdata;
      if (cmd_wr) dma_mode_q <= wdata[7];
      if (fifo_moved) level_q <= DATA_W'(fifo_lvl_nx);
      if (dma_done) begin
        seq_q   <= '0;
        level_q <= '0;
      end
    end
  end

  always_comb begin
    case (addr)
      A_CNT_LO: rdata = rcnt[0];
      A_CNT_HI: rdata = rcnt[1];
      A_FIFO:   rdata = fifo_head;
      A_STAT:   rdata = stat_q;
      A_RSN:    rdata = rsn_q;
      A_SEQ:    rdata = seq_q;
      A_LEVEL:  rdata = level_q;
      A_IDENT:  rdata = IDENT_CODE;
      default:  rdata = '0;
    endcase
  end

  assign dma_mode   = dma_mode_q;
  assign xfer_bytes = ({rcnt[1], rcnt[0]} == '0) ? {1'b1, {CNT_W{1'b0}}}
                                                 : {1'b0, rcnt[1], rcnt[0]};
endmodule

// File: rtl/scsi_regif_chk.sv
module scsi_regif_chk
  import scsi_regif_pkg::*;
#(
  parameter int FIFO_DEPTH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              wr_en,
  input logic              rd_en,
  input logic              dma_done,
  input logic              irq,
  input logic              dma_mode,
  input logic [CNT_W:0]    xfer_bytes,
  input logic [DATA_W-1:0] status,
  input logic [DATA_W-1:0] cfg,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] level
);
  AST_ACK_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && addr == A_RSN && !dma_done |=> !irq && !status[ST_PEND]); // R5

  AST_CNT_WRITE_CLEARS_TC: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (addr == A_CNT_LO || addr == A_CNT_HI) && !dma_done |=> !status[ST_TC]); // R3

  AST_CMD_SETS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_CMD |=> dma_mode == $past(wdata[7])); // R2

  AST_DONE_COMPLETES: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> irq && status[ST_PEND] && status[ST_TC] && xfer_bytes[CNT_W]); // R6

  AST_BUSRST_MUTED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_CMD && wdata[6:0] == OP_BUSRST && cfg[CFG_MUTE] && !irq && !dma_done
    |=> !irq); // R7

  AST_BUSRST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_CMD && wdata[6:0] == OP_BUSRST && !cfg[CFG_MUTE] |=> irq); // R7

  AST_DONE_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done && rd_en && addr == A_RSN |=> irq); // R10

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(FIFO_DEPTH+1))'(FIFO_DEPTH)); // R9
endmodule

bind scsi_regif scsi_regif_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .rd_en(rd_en), .dma_done(dma_done), .irq(irq), .dma_mode(dma_mode),
  .xfer_bytes(xfer_bytes), .status(stat_q), .cfg(cfg_q), .level(fifo_lvl)
);

// File: tb/scsi_regif_tb.sv
module scsi_regif_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0, dma_done = 1'b0;
  logic [7:0] rdata;
  logic       irq, dma_mode;
  logic [16:0] xfer_bytes;

  int total = 0, bad = 0;
  bit live = 0;

  // behavioural reference
  byte unsigned m_wlo, m_whi, m_cfg, m_rlo, m_rhi, m_seq, m_lvl, m_stat, m_rsn;
  bit m_irq, m_dma, m_pu, m_po;
  byte unsigned m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_regif u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .dma_done(dma_done), .irq(irq),
    .dma_mode(dma_mode), .xfer_bytes(xfer_bytes)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic byte unsigned m_read(input logic [5:0] a);
    case (a)
      6'h00: return m_rlo;
      6'h01: return m_rhi;
      6'h02: return (m_q.size() > 0) ? m_q[0] : 8'h00;
      6'h04: return m_stat;
      6'h05: return m_rsn;
      6'h06: return m_seq;
      6'h07: return m_lvl;
      6'h0E: return 8'h04;
      default: return 8'h00;
    endcase
  endfunction

  function automatic string tag_of(input logic [5:0] a);
    case (a)
      6'h00, 6'h01: return "R1 counter read";
      6'h02, 6'h07: return "R9 fifo read";
      6'h04: return "R4 status read";
      6'h05: return "R5 reason read";
      default: return "R8 register read";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wlo = 0; m_whi = 0; m_cfg = 0; m_rlo = 0; m_rhi = 0; m_seq = 0;
      m_lvl = 0; m_stat = 0; m_rsn = 0; m_irq = 0; m_dma = 0;
      m_q.delete();
    end else begin
      m_pu = wr_en && addr == 6'h02 && m_q.size() < 32;
      m_po = rd_en && addr == 6'h02 && m_q.size() > 0;
      if (rd_en && addr == 6'h05) begin m_stat &= 8'h1F; m_irq = 0; end
      if (wr_en) begin
        case (addr)
          6'h00: begin m_wlo = wdata; m_stat &= 8'hEF; end
          6'h01: begin m_whi = wdata; m_stat &= 8'hEF; end
          6'h08: m_cfg = wdata;
          6'h03: begin
            m_dma = wdata[7];
            if (wdata[7]) begin m_rlo = m_wlo; m_rhi = m_whi; end
            if (wdata[6:0] == 7'h03) begin
              m_rsn = 8'h80;
              if (!m_cfg[6]) m_irq = 1;
            end
          end
          default: ;
        endcase
      end
      if (m_po) void'(m_q.pop_front());
      if (m_pu) m_q.push_back(wdata);
      if (m_pu || m_po) m_lvl = m_q.size();
      if (dma_done) begin
        m_stat |= 8'h90; m_rsn = 8'h10; m_irq = 1;
        m_rlo = 0; m_rhi = 0; m_seq = 0; m_lvl = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (live) begin
      chk(irq == m_irq, "R5 irq vs model", irq, m_irq);
      chk(dma_mode == m_dma, "R2 dma_mode vs model", dma_mode, m_dma);
      chk(xfer_bytes == (({m_rhi, m_rlo} == 0) ? 17'h10000 : {1'b0, m_rhi, m_rlo}),
          "R1 xfer_bytes vs model", xfer_bytes, {m_rhi, m_rlo});
    end
  end

  task automatic cyc(input bit we, input bit re, input logic [5:0] a,
                     input logic [7:0] d, input bit dn, output logic [7:0] got);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; dma_done = dn;
    #1;
    got = rdata;
    if (re) chk(rdata == m_read(a), tag_of(a), rdata, m_read(a));
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 0; rd_en = 0; dma_done = 0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    logic [7:0] g;
    cyc(1, 0, a, d, 0, g);
    idle();
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] v);
    cyc(0, 1, a, 8'h00, 0, v);
    idle();
  endtask

  initial begin : wdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] v, g;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; live = 1;

    // R8 reset values
    rd(6'h0E, v); chk(v == 8'h04, "R8 ident", v, 4);
    rd(6'h04, v); chk(v == 8'h00, "R8 status", v, 0);
    chk(irq == 0 && dma_mode == 0, "R8 irq/mode", {irq, dma_mode}, 0);
    rd(6'h07, v); chk(v == 8'h00, "R8 level", v, 0);

    // R1 R2 counter load
    wr(6'h00, 8'h34); wr(6'h01, 8'h12);
    rd(6'h00, v); chk(v == 8'h00, "R3 readable counter untouched", v, 0);
    wr(6'h03, 8'h80);
    chk(dma_mode == 1, "R2 dma mode", dma_mode, 1);
    rd(6'h00, v); chk(v == 8'h34, "R1 low byte", v, 8'h34);
    rd(6'h01, v); chk(v == 8'h12, "R1 high byte", v, 8'h12);
    chk(xfer_bytes == 17'h1234, "R1 length", xfer_bytes, 17'h1234);
    wr(6'h00, 8'h99); wr(6'h03, 8'h00);
    chk(dma_mode == 0, "R2 pio mode", dma_mode, 0);
    chk(xfer_bytes == 17'h1234, "R2 pio keeps counter", xfer_bytes, 17'h1234);

    // R6 completion, R5 acknowledge, R4 no side effect
    cyc(0, 0, 6'h00, 8'h00, 1, g); idle();
    chk(irq == 1, "R6 irq", irq, 1);
    chk(xfer_bytes == 17'h10000, "R6 zero counter means 65536", xfer_bytes, 17'h10000);
    rd(6'h04, v); chk(v == 8'h90, "R6 status", v, 8'h90);
    rd(6'h04, v); chk(v == 8'h90 && irq, "R4 status read no effect", v, 8'h90);
    rd(6'h05, v); chk(v == 8'h10, "R6 reason", v, 8'h10);
    chk(irq == 0, "R5 irq cleared", irq, 0);
    rd(6'h04, v); chk(v == 8'h10, "R5 keeps tc", v, 8'h10);

    // R3
    wr(6'h01, 8'h00);
    rd(6'h04, v); chk(v == 8'h00, "R3 tc cleared", v, 0);

    // R7 bus reset
    wr(6'h08, 8'h00); wr(6'h03, 8'h03);
    chk(irq == 1, "R7 irq raised", irq, 1);
    rd(6'h05, v); chk(v == 8'h80, "R7 reason", v, 8'h80);
    wr(6'h08, 8'h40); wr(6'h03, 8'h03);
    chk(irq == 0, "R7 irq muted", irq, 0);
    rd(6'h05, v); chk(v == 8'h80, "R7 reason muted", v, 8'h80);

    // R9 fifo
    wr(6'h02, 8'hA1); wr(6'h02, 8'hB2); wr(6'h02, 8'hC3);
    rd(6'h07, v); chk(v == 8'd3, "R9 level 3", v, 3);
    rd(6'h02, v); chk(v == 8'hA1, "R9 order", v, 8'hA1);
    rd(6'h02, v); chk(v == 8'hB2, "R9 order", v, 8'hB2);
    rd(6'h02, v); chk(v == 8'hC3, "R9 order", v, 8'hC3);
    rd(6'h02, v); chk(v == 8'h00, "R9 empty pop", v, 0);
    rd(6'h07, v); chk(v == 8'd0, "R9 level 0", v, 0);
    for (int i = 0; i < 33; i++) wr(6'h02, 8'(i + 8'h40));
    rd(6'h07, v); chk(v == 8'd32, "R9 full level", v, 32);
    for (int i = 0; i < 32; i++) begin
      rd(6'h02, v); chk(v == 8'(i + 8'h40), "R9 full drain", v, i + 8'h40);
    end
    rd(6'h07, v); chk(v == 8'd0, "R9 drained", v, 0);

    // R10 same-cycle priority
    cyc(0, 1, 6'h05, 8'h00, 1, g); idle();
    chk(irq == 1, "R10 done beats acknowledge", irq, 1);
    rd(6'h04, v); chk(v == 8'h90, "R10 status", v, 8'h90);
    rd(6'h05, v);
    wr(6'h00, 8'h55); wr(6'h01, 8'h66);
    cyc(1, 0, 6'h03, 8'h80, 1, g); idle();
    rd(6'h00, v); chk(v == 8'h00, "R10 done beats reload", v, 0);
    chk(dma_mode == 1, "R10 mode still set", dma_mode, 1);
    cyc(1, 0, 6'h00, 8'h11, 1, g); idle();
    rd(6'h04, v); chk(v[4] == 1, "R10 done beats tc clear", v, 8'h90);
    rd(6'h05, v); chk(v == 8'h10, "R10 reason", v, 8'h10);

    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule